// File: doc/BRIEF.md
# Half-Rate TMDS Lane Serializer

This block turns the three 10-bit TMDS symbols produced for each pixel into serial bit streams for the red, green and blue lanes of a DVI/HDMI-style link. It does not run at the full bit rate, which is ten times the pixel rate. It runs from a serializer clock at half that rate and hands out two bits per lane on every cycle. An external double-data-rate output cell sends one bit of each pair on the rising edge and the other on the falling edge. With a 25 MHz pixel clock, the serializer clock is 125 MHz and each lane carries 250 Mb/s.

Symbols are captured on the pixel clock into a holding register. The serializer clock must come from the same source and be phase aligned to the pixel clock, with five serializer cycles per pixel. A modulo-5 phase counter reloads all lane shift registers together one serializer cycle after each pixel edge. Between reloads, each register moves two bits per cycle. A fourth lane carries the pixel clock as a bit pattern, in step with the data words. The complementary pad signals, the output cells and the clock generator are outside this block.

Top module: `tmds_ddr_serializer`

## Requirements
- R1: The reset `rst_n` is synchronous and active low in both clock domains. While it is low, and in the first serializer cycle after it is released, every output pair is 2'b00.
- R2: On each rising pixel-clock edge, the block captures the three input symbols. Reset must be released so that the first serializer edge with `rst_n` high coincides with a pixel-clock edge.
- R3: Bit order is least significant first. In each output pair, bit [0] is the rise bit and carries the earlier serial bit, and bit [1] is the fall bit.
- R4: A symbol captured at the pixel edge that coincides with serializer edge 5k is emitted during the five serializer cycles that follow edges 5k+1 to 5k+5. Cycle s of those five (s = 0..4) shows symbol bits {2s+1, 2s} on {fall, rise}.
- R5: Lane mapping: `red_pair_o` carries `sym_red`, `green_pair_o` carries `sym_green` and `blue_pair_o` carries `sym_blue`. The three lanes are independent of each other.
- R6: Over the same five cycles, the clock lane `clk_pair_o` shows 2'b11, 2'b11, 2'b01, 2'b00, 2'b00 (bit [0] = rise). This gives five high bits and then five low bits per pixel.
- R7: The phase counter counts 0 to 4 and wraps. A reload happens once every five serializer cycles and never in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Half-bit-rate serializer clock, five cycles per pixel, phase aligned to pix_clk |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| sym_red | input | 10 | TMDS symbol for the red channel |
| sym_green | input | 10 | TMDS symbol for the green channel |
| sym_blue | input | 10 | TMDS symbol for the blue channel |
| red_pair_o | output | 2 | Red lane (lane 2) pair, [0] rise, [1] fall |
| green_pair_o | output | 2 | Green lane (lane 1) pair |
| blue_pair_o | output | 2 | Blue lane (lane 0) pair |
| clk_pair_o | output | 2 | Clock lane (lane 3) pair |

## Verification
The bench reassembles every ten received bits into a word and compares it with the symbol presented for that pixel. A swapped rise/fall order or an MSB-first shift shows up as bit-reversed or pair-swapped words. The symbols 10'h155 and 10'h2AA make pair swaps visible, and 10'h001 and 10'h200 catch an off-by-one slot. A reload phase one cycle early or late gives words rotated by two bits. The reload could also sample the holding register as it changes, which gives a mix of the current and previous symbol. Back-to-back differing symbols catch both faults. A faulty clock-lane pattern or a crossed lane mapping fails the per-cycle clock check or the per-lane word comparison.

// File: rtl/tmds_ser_pkg.sv
// Package: shared widths and types for the half-rate TMDS serializer.
// Assumes one symbol per lane per pixel and an even symbol width.
package tmds_ser_pkg;
    localparam int SYM_W_DEF = 10;
    localparam int BPC_DEF   = 2;   // bits leaving per serializer cycle
    localparam int LANES     = 4;   // blue, green, red, clock
endpackage

// File: rtl/tmds_sym_hold.sv
// Holding register: captures the colour symbols on the pixel clock.
// Assumes the serializer domain reads it only at least one serializer
// cycle after a pixel edge, when it is stable.
module tmds_sym_hold #(
    parameter int SYM_W = 10
) (
    input  logic             pix_clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] red_i,
    input  logic [SYM_W-1:0] green_i,
    input  logic [SYM_W-1:0] blue_i,
    output logic [SYM_W-1:0] red_o,
    output logic [SYM_W-1:0] green_o,
    output logic [SYM_W-1:0] blue_o
);
    // Capture the three symbols once per pixel.
    always_ff @(posedge pix_clk) begin
        if (!rst_n) begin
            red_o   <= '0;
            green_o <= '0;
            blue_o  <= '0;
        end else begin
            red_o   <= red_i;
            green_o <= green_i;
            blue_o  <= blue_i;
        end
    end
endmodule

// File: rtl/tmds_phase_cnt.sv
// Phase counter: modulo-PHASES count in the serializer domain. It flags
// the reload cycle at LOAD_PHASE. Assumes reset is released so that the
// first counting edge coincides with a pixel edge.
module tmds_phase_cnt #(
    parameter int PHASES     = 5,
    parameter int LOAD_PHASE = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o
);
    localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASES - 1);
    localparam logic [CW-1:0] LDP  = CW'(LOAD_PHASE);

    logic [CW-1:0] cnt_q;

    // Step the phase and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // The reload strobe is decoded from the phase.
    always_comb load_o = (cnt_q == LDP);

    // R7: the phase never leaves its range
    a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R7: reloads are never adjacent
    a_r7_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/tmds_lane_shift.sv
// Lane shifter: parallel load of one symbol, then it moves BPC bits per
// cycle towards bit 0. The low BPC bits form the output pair, with bit 0
// (rise) the earlier serial bit.
module tmds_lane_shift #(
    parameter int SYM_W = 10,
    parameter int BPC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [SYM_W-1:0] word_i,
    output logic [BPC-1:0]   pair_o
);
    logic [SYM_W-1:0] shift_q;

    // Load on the reload strobe, otherwise shift right by BPC.
    always_ff @(posedge clk) begin
        if (!rst_n)    shift_q <= '0;
        else if (ld_i) shift_q <= word_i;
        else           shift_q <= shift_q >> BPC;
    end

    // Drive the pair from the bottom of the register.
    always_comb pair_o = shift_q[BPC-1:0];

    // R4: without a load, the next pair is the bits just above the current one
    a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> pair_o == $past(shift_q[2*BPC-1:BPC]));
    // R1: reset empties the lane
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> pair_o == '0);
endmodule

// File: rtl/tmds_ddr_serializer.sv
// Top: half-rate TMDS serializer for three colour lanes plus a clock lane.
// It needs ser_clk at five times pix_clk, from the same source and phase
// aligned. The pair outputs feed external DDR output cells, with [0] on
// the rising edge and [1] on the falling edge.
module tmds_ddr_serializer
    import tmds_ser_pkg::*;
#(
    parameter int SYM_W = SYM_W_DEF,
    parameter int BPC   = BPC_DEF
) (
    input  logic             ser_clk,
    input  logic             pix_clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_red,
    input  logic [SYM_W-1:0] sym_green,
    input  logic [SYM_W-1:0] sym_blue,
    output logic [BPC-1:0]   red_pair_o,
    output logic [BPC-1:0]   green_pair_o,
    output logic [BPC-1:0]   blue_pair_o,
    output logic [BPC-1:0]   clk_pair_o
);
    localparam int PHASES = SYM_W / BPC;
    localparam logic [SYM_W-1:0] CLK_WORD = {SYM_W{1'b1}} >> (SYM_W - SYM_W / 2);

    logic [SYM_W-1:0] hold_r, hold_g, hold_b;
    logic             load;
    logic [SYM_W-1:0] lane_word [LANES];
    logic [BPC-1:0]   lane_pair [LANES];

    tmds_sym_hold #(.SYM_W(SYM_W)) u_hold (
        .pix_clk (pix_clk),
        .rst_n   (rst_n),
        .red_i   (sym_red),
        .green_i (sym_green),
        .blue_i  (sym_blue),
        .red_o   (hold_r),
        .green_o (hold_g),
        .blue_o  (hold_b)
    );

    tmds_phase_cnt #(.PHASES(PHASES), .LOAD_PHASE(1)) u_phase (
        .clk    (ser_clk),
        .rst_n  (rst_n),
        .load_o (load)
    );

    // Lane sources: 0 blue, 1 green, 2 red, 3 the fixed clock word.
    always_comb begin
        lane_word[0] = hold_b;
        lane_word[1] = hold_g;
        lane_word[2] = hold_r;
        lane_word[3] = CLK_WORD;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tmds_lane_shift #(.SYM_W(SYM_W), .BPC(BPC)) u_sh (
            .clk    (ser_clk),
            .rst_n  (rst_n),
            .ld_i   (load),
            .word_i (lane_word[l]),
            .pair_o (lane_pair[l])
        );
    end

    // Route the lane pairs to the ports.
    always_comb begin
        blue_pair_o  = lane_pair[0];
        green_pair_o = lane_pair[1];
        red_pair_o   = lane_pair[2];
        clk_pair_o   = lane_pair[3];
    end

    // R6: the cycle after a reload starts the clock lane high on both edges
    a_r6_clk_start: assert property (@(posedge ser_clk) disable iff (!rst_n)
        load |=> clk_pair_o == '1);
    // R6: the pair before a reload (last slot of the word) is low
    a_r6_clk_end: assert property (@(posedge ser_clk) disable iff (!rst_n)
        load |-> clk_pair_o == '0);
endmodule

// File: tb/sim_tmds_ddr_serializer.sv
module sim_tmds_ddr_serializer;
    localparam int NW = 64;

    logic       ser_clk = 1'b0;
    logic       pix_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [9:0] sym_red, sym_green, sym_blue;
    logic [1:0] red_pair_o, green_pair_o, blue_pair_o, clk_pair_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit run    = 1'b0;
    bit ended  = 1'b0;
    int j      = 0;

    logic [9:0] sent_r [NW];
    logic [9:0] sent_g [NW];
    logic [9:0] sent_b [NW];
    logic [9:0] acc_r, acc_g, acc_b;

    tmds_ddr_serializer u0 (
        .ser_clk      (ser_clk),
        .pix_clk      (pix_clk),
        .rst_n        (rst_n),
        .sym_red      (sym_red),
        .sym_green    (sym_green),
        .sym_blue     (sym_blue),
        .red_pair_o   (red_pair_o),
        .green_pair_o (green_pair_o),
        .blue_pair_o  (blue_pair_o),
        .clk_pair_o   (clk_pair_o)
    );

    // 125 MHz serializer clock, first rise at 4 ns.
    initial begin
        #4;
        forever begin ser_clk = 1'b1; #4; ser_clk = 1'b0; #4; end
    end
    // Pixel clock at one fifth of that, rising with every fifth serializer edge.
    initial begin
        #4;
        forever begin pix_clk = 1'b1; #20; pix_clk = 1'b0; #20; end
    end

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected clock-lane pair for a word slot: bits of 10'b00000_11111.
    function automatic logic [1:0] clk_exp(input int slot);
        logic [9:0] w;
        w = 10'b0000011111;
        return {w[2*slot+1], w[2*slot]};
    endfunction

    // Monitor: reassemble the lane words away from the active edge.
    always @(negedge ser_clk) begin
        if (run) begin
            if (j == 0) begin
                // R1: the first cycle after release is still idle
                chk("R1", {2'b0, red_pair_o, green_pair_o, blue_pair_o, clk_pair_o}, 10'd0);
            end else begin
                automatic int slot = (j - 1) % 5;
                automatic int w    = (j - 1) / 5;
                if (w < NW) begin
                    acc_r[2*slot] = red_pair_o[0];   acc_r[2*slot+1] = red_pair_o[1];
                    acc_g[2*slot] = green_pair_o[0]; acc_g[2*slot+1] = green_pair_o[1];
                    acc_b[2*slot] = blue_pair_o[0];  acc_b[2*slot+1] = blue_pair_o[1];
                    // R6 clock lane pattern per slot
                    chk("R6", {8'd0, clk_pair_o}, {8'd0, clk_exp(slot)});
                    if (slot == 4) begin
                        // R2 R3 R4 R5: each lane word equals its own symbol
                        chk("R5/R4 red",   acc_r, sent_r[w]);
                        chk("R5/R3 green", acc_g, sent_g[w]);
                        chk("R2/R3 blue",  acc_b, sent_b[w]);
                    end
                end
            end
            j++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] corner [6];
        void'($urandom(32'd1234));
        corner[0] = 10'h000; corner[1] = 10'h3FF; corner[2] = 10'h155;
        corner[3] = 10'h2AA; corner[4] = 10'h001; corner[5] = 10'h200;
        for (int k = 0; k < NW; k++) begin
            if (k < 6) begin
                sent_r[k] = corner[k];
                sent_g[k] = corner[5-k];
                sent_b[k] = ~corner[k];
            end else begin
                sent_r[k] = 10'($urandom);
                sent_g[k] = 10'($urandom);
                sent_b[k] = 10'($urandom);
            end
        end
        sym_red = sent_r[0]; sym_green = sent_g[0]; sym_blue = sent_b[0];
        repeat (3) @(posedge pix_clk);
        @(negedge ser_clk);
        // R1: outputs are idle while reset is held
        chk("R1", {2'b0, red_pair_o, green_pair_o, blue_pair_o, clk_pair_o}, 10'd0);
        @(posedge pix_clk);
        #38;
        rst_n = 1'b1;   // the next serializer edge is a pixel edge
        run   = 1'b1;
        for (int k = 1; k < NW; k++) begin
            @(negedge pix_clk);
            sym_red = sent_r[k]; sym_green = sent_g[k]; sym_blue = sent_b[k];
        end
        wait (j > 5 * NW + 1);
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule